// File: doc/BRIEF.md
# DDR Read Burst Output Sequencer

This block produces the read-data side of a double-data-rate memory model, written as synthesizable logic that runs on the command clock. A READ command carries a bank, a column and an auto-precharge flag. After the programmed CAS latency, the block presents one burst element pair per clock. The element for the rising edge and the element for the falling edge come out on separate buses. The storage array is not modelled: each element's value is formed from its bank and column address.

Alongside the data, the block drives four things:
- the per-half-clock strobe level;
- a strobe drive enable that also covers the low preamble clock;
- a data output enable, where low stands for high impedance;
- a one-clock precharge request for the bank of any burst that asked for auto-precharge.

A READ can arrive on any clock. If it arrives while a burst is still running, it cuts that burst short. If it arrives just as a burst ends, it joins on. Either way its data follows the previous pair with no gap, no postamble and no preamble.

Burst length and CAS latency are static configuration inputs. They must only change while no read is in flight.

Top module: `ddr_rd_seq`

## Requirements
- R1: While rst_ni is low, and after it is released with no READ issued, dq_oe_o, dqs_en_o, dqs_o, pre_req_o, dq_rise_o and dq_fall_o are all zero.
- R2: A READ sampled with rd_i high in clock n puts its first element pair on the outputs in clock n+2 when cfg_cl_i is 0, and in clock n+3 when cfg_cl_i is 1. dq_oe_o is high in that clock.
- R3: Each element carries the value bank*2^COL_W + column, zero-extended to DW bits. dq_rise_o holds the even element of the pair and dq_fall_o holds the odd element.
- R4: cfg_bl_i selects the burst length: 0 gives 2 elements, 1 gives 4, and 2 or 3 give 8. Element j of a burst of length L sits at column (start & ~(L-1)) | (((start & ~1) + j) mod L), so the order is sequential and wraps inside the L-aligned block.
- R5: A burst that nothing interrupts keeps dq_oe_o high for exactly L/2 clocks. dq_oe_o then falls, unless a joining READ follows.
- R6: In every clock where dq_oe_o is high, dqs_en_o is high and dqs_o is 2'b10: bit 1 is the strobe level during the rising-edge element and bit 0 is the level during the falling-edge element. The strobe is therefore low during the last element (postamble).
- R7: In the clock just before a burst's first pair, when no burst is being output in that clock, dqs_en_o is 1, dqs_o is 2'b00 and dq_oe_o is 0 (preamble).
- R8: A READ issued x clocks after an earlier READ, with x below that burst's pair count, cuts the earlier burst to x pairs. The new burst's first pair follows in the next clock. A READ that arrives exactly when the earlier burst ends joins on directly. In both cases dq_oe_o stays high with no preamble.
- R9: If the auto-precharge flag was set with the READ, pre_req_o has exactly the bank's bit high for one clock, in the clock after the burst's last pair. With the flag clear, pre_req_o stays zero.
- R10: An auto-precharge burst that is cut short raises its request in the first clock of the following burst.
- R11: Whenever dq_oe_o is low, dq_rise_o and dq_fall_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_bl_i | input | 2 | Burst length select (0:2, 1:4, 2/3:8) |
| cfg_cl_i | input | 1 | CAS latency select (0:2 clocks, 1:3 clocks) |
| rd_i | input | 1 | READ command strobe |
| rd_bank_i | input | BANK_W | Bank of the READ |
| rd_col_i | input | COL_W | Starting column of the READ |
| rd_ap_i | input | 1 | Auto-precharge flag of the READ |
| dq_rise_o | output | DW | Rising-edge data element |
| dq_fall_o | output | DW | Falling-edge data element |
| dq_oe_o | output | 1 | Data output enable (low means high impedance) |
| dqs_o | output | 2 | Strobe level for the rising half and the falling half |
| dqs_en_o | output | 1 | Strobe drive enable |
| pre_req_o | output | 2**BANK_W | One-clock precharge request per bank |

## Verification
The bench targets four kinds of corner case.

1. Starting columns that are odd and sit near the end of their aligned block, under every burst length. A design with wrong wrap or pairing would send columns from the next block, or would start a pair on an odd column.
2. READs issued one, two and four clocks apart. These cover truncation, exact joining and a READ on every clock. A wrong design would let the old burst run over the new one, leave a one-clock gap with a stray preamble, or drop the enable between bursts.
3. Auto-precharge on both cut-short and completed bursts. A wrong design would fire the request at the wrong clock, for the wrong bank, or never fire it for a cut-short burst.
4. Switching between both CAS latencies, which shows any off-by-one in the command delay line.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;
  typedef enum logic [1:0] {BL_2 = 2'd0, BL_4 = 2'd1, BL_8 = 2'd2, BL_8X = 2'd3} bl_sel_e;

  function automatic logic [2:0] pair_cnt(input logic [1:0] code);
    case (bl_sel_e'(code))
      BL_2:    return 3'd1;
      BL_4:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ddr_rd_cmd_pipe.sv
module ddr_rd_cmd_pipe #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int DEPTH  = 2,
  localparam int TW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              ap_i,
  input  logic [TW-1:0]     tap_i,
  output logic              launch_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o,
  output logic              ap_o
);
  typedef struct packed {
    logic              vld;
    logic              ap;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
  } stage_t;

  stage_t stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    stage_t nxt;
    if (i == 0) begin : g_head
      assign nxt = '{vld: rd_i, ap: ap_i, bank: bank_i, col: col_i};
    end else begin : g_tail
      assign nxt = stg[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[i] <= '0;
      else         stg[i] <= nxt;
    end
  end

  // tap chosen so the engine loads one clock before the first pair
  assign launch_o = stg[tap_i].vld;
  assign bank_o   = stg[tap_i].bank;
  assign col_o    = stg[tap_i].col;
  assign ap_o     = stg[tap_i].ap;
endmodule

// File: rtl/ddr_rd_burst_ctl.sv
module ddr_rd_burst_ctl
  import ddr_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int BL_MAX = 8,
  localparam int PW    = $clog2(BL_MAX / 2),
  localparam int NBANK = 2 ** BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bl_i,
  input  logic              launch_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              ap_i,
  output logic              act_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o,
  output logic [PW-1:0]     pidx_o,
  output logic [COL_W-1:0]  mask_o,
  output logic              dqs_en_o,
  output logic [NBANK-1:0]  pre_req_o
);
  logic [PW-1:0] last_q;
  logic          ap_q;
  logic          ends;
  logic [2:0]    npairs;

  assign npairs = pair_cnt(bl_i);
  assign ends   = act_o && (launch_i || pidx_o == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o  <= 1'b0;
      bank_o <= '0;
      col_o  <= '0;
      pidx_o <= '0;
      last_q <= '0;
      mask_o <= '0;
      ap_q   <= 1'b0;
    end else if (launch_i) begin
      act_o  <= 1'b1;
      bank_o <= bank_i;
      col_o  <= col_i & ~COL_W'(1);
      pidx_o <= '0;
      last_q <= PW'(npairs - 3'd1);
      mask_o <= COL_W'({npairs, 1'b0} - 4'd1);
      ap_q   <= ap_i;
    end else if (act_o) begin
      if (pidx_o == last_q) act_o <= 1'b0;
      else                  pidx_o <= pidx_o + PW'(1);
    end
  end

  // request fires the clock after the final pair, also when cut short
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pre_req_o <= '0;
    else if (ends && ap_q) pre_req_o <= NBANK'(1) << bank_o;
    else                   pre_req_o <= '0;
  end

  assign dqs_en_o = act_o | launch_i;
endmodule

// File: rtl/ddr_rd_data_fmt.sv
module ddr_rd_data_fmt #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int DW     = 16,
  parameter int PW     = 2
) (
  input  logic              act_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [PW-1:0]     pidx_i,
  input  logic [COL_W-1:0]  mask_i,
  output logic [DW-1:0]     rise_o,
  output logic [DW-1:0]     fall_o
);
  logic [DW-1:0] elem [2];

  for (genvar e = 0; e < 2; e++) begin : g_elem
    logic [COL_W-1:0] off;
    logic [COL_W-1:0] col;
    assign off = col_i + COL_W'({pidx_i, 1'b0}) + COL_W'(e);
    assign col = (col_i & ~mask_i) | (off & mask_i);
    assign elem[e] = act_i ? ((DW'(bank_i) << COL_W) | DW'(col)) : '0;
  end

  assign rise_o = elem[0];
  assign fall_o = elem[1];
endmodule

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int DW     = 16,
  parameter int BL_MAX = 8,
  parameter int CL_MAX = 3,
  localparam int NBANK = 2 ** BANK_W,
  localparam int DEPTH = CL_MAX - 1,
  localparam int TW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW    = $clog2(BL_MAX / 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cfg_bl_i,
  input  logic              cfg_cl_i,
  input  logic              rd_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic [COL_W-1:0]  rd_col_i,
  input  logic              rd_ap_i,
  output logic [DW-1:0]     dq_rise_o,
  output logic [DW-1:0]     dq_fall_o,
  output logic              dq_oe_o,
  output logic [1:0]        dqs_o,
  output logic              dqs_en_o,
  output logic [NBANK-1:0]  pre_req_o
);
  logic              launch, l_ap, act;
  logic [BANK_W-1:0] l_bank, e_bank;
  logic [COL_W-1:0]  l_col, e_col, e_mask;
  logic [PW-1:0]     e_pidx;

  ddr_rd_cmd_pipe #(.BANK_W(BANK_W), .COL_W(COL_W), .DEPTH(DEPTH)) u_pipe (
    .clk_i, .rst_ni, .rd_i, .bank_i(rd_bank_i), .col_i(rd_col_i), .ap_i(rd_ap_i),
    .tap_i(TW'(cfg_cl_i)), .launch_o(launch), .bank_o(l_bank), .col_o(l_col), .ap_o(l_ap)
  );

  ddr_rd_burst_ctl #(.BANK_W(BANK_W), .COL_W(COL_W), .BL_MAX(BL_MAX)) u_ctl (
    .clk_i, .rst_ni, .bl_i(cfg_bl_i), .launch_i(launch), .bank_i(l_bank), .col_i(l_col),
    .ap_i(l_ap), .act_o(act), .bank_o(e_bank), .col_o(e_col), .pidx_o(e_pidx),
    .mask_o(e_mask), .dqs_en_o(dqs_en_o), .pre_req_o(pre_req_o)
  );

  ddr_rd_data_fmt #(.BANK_W(BANK_W), .COL_W(COL_W), .DW(DW), .PW(PW)) u_fmt (
    .act_i(act), .bank_i(e_bank), .col_i(e_col), .pidx_i(e_pidx), .mask_i(e_mask),
    .rise_o(dq_rise_o), .fall_o(dq_fall_o)
  );

  assign dq_oe_o = act;
  assign dqs_o   = act ? 2'b10 : 2'b00;
endmodule

// File: rtl/ddr_rd_seq_chk.sv
module ddr_rd_seq_chk #(
  parameter int DW    = 16,
  parameter int NBANK = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_cl_i,
  input logic             rd_i,
  input logic [DW-1:0]    dq_rise_o,
  input logic [DW-1:0]    dq_fall_o,
  input logic             dq_oe_o,
  input logic [1:0]       dqs_o,
  input logic             dqs_en_o,
  input logic [NBANK-1:0] pre_req_o
);
  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_latency_cl2_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && !cfg_cl_i && $past(rd_i, 2) && !$past(cfg_cl_i, 2)) |-> dq_oe_o);

  assert_strobe_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (dqs_en_o && dqs_o == 2'b10));

  assert_preamble_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dqs_en_o && !dq_oe_o) |-> (dqs_o == 2'b00) ##1 dq_oe_o);

  assert_pre_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pre_req_o));

  assert_pre_after_burst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age != 2'd0 && pre_req_o != '0) |-> $past(dq_oe_o));

  assert_idle_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> (dq_rise_o == '0 && dq_fall_o == '0));
endmodule

bind ddr_rd_seq ddr_rd_seq_chk #(.DW(DW), .NBANK(NBANK)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_cl_i(cfg_cl_i), .rd_i(rd_i),
  .dq_rise_o(dq_rise_o), .dq_fall_o(dq_fall_o), .dq_oe_o(dq_oe_o),
  .dqs_o(dqs_o), .dqs_en_o(dqs_en_o), .pre_req_o(pre_req_o)
);

// File: tb/ddr_rd_seq_bench.sv
module ddr_rd_seq_bench;
  localparam int BANK_W = 2, COL_W = 10, DW = 16, NBANK = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] cfg_bl_i = 2'd1;
  logic cfg_cl_i = 1'b0, rd_i = 1'b0, rd_ap_i = 1'b0;
  logic [BANK_W-1:0] rd_bank_i = '0;
  logic [COL_W-1:0] rd_col_i = '0;
  logic [DW-1:0] dq_rise_o, dq_fall_o;
  logic dq_oe_o, dqs_en_o;
  logic [1:0] dqs_o;
  logic [NBANK-1:0] pre_req_o;

  always #2 clk_i = ~clk_i;

  ddr_rd_seq u_ddr_rd_seq (.*);

  int checks = 0, errors = 0, cyc = 0, nid = 0;
  bit done = 0;
  string dtag = "R3", ptag = "R9";
  int own [int];
  logic [DW-1:0] er [int], ef [int];
  int id_bank [int];
  bit id_ap [int];

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: got %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int bank, input int col);
    return DW'(bank * (1 << COL_W) + col);
  endfunction

  task automatic compare();
    bit eo, en;
    logic [NBANK-1:0] pe;
    eo = own.exists(cyc);
    en = own.exists(cyc + 1);
    pe = '0;
    if (own.exists(cyc - 1) && (!eo || own[cyc] != own[cyc-1]) && id_ap[own[cyc-1]])
      pe = NBANK'(1) << id_bank[own[cyc-1]];
    chk("R2/R5 oe", DW'(dq_oe_o), DW'(eo));
    chk(eo ? "R6 dqs" : "R7 dqs", DW'(dqs_o), eo ? DW'(2) : DW'(0));
    chk(eo ? "R6 dqs_en" : "R7 dqs_en", DW'(dqs_en_o), DW'(eo || en));
    chk(eo ? dtag : "R11", dq_rise_o, eo ? er[cyc] : '0);
    chk(eo ? dtag : "R11", dq_fall_o, eo ? ef[cyc] : '0);
    chk(ptag, DW'(pre_req_o), DW'(pe));
  endtask

  // record a READ issued in cycle cyc into the reference schedule
  task automatic model_read(input int bank, input int col, input bit ap);
    int s, np, blen, lo;
    s = cyc + (cfg_cl_i ? 3 : 2);
    for (int k = s; k < s + 8; k++)
      if (own.exists(k)) begin own.delete(k); er.delete(k); ef.delete(k); end
    np = (cfg_bl_i == 2'd0) ? 1 : (cfg_bl_i == 2'd1) ? 2 : 4;
    blen = 2 * np;
    lo = (col & ~1) % blen;
    for (int p = 0; p < np; p++) begin
      own[s+p] = nid;
      er[s+p] = pat(bank, (col / blen) * blen + (lo + 2*p) % blen);
      ef[s+p] = pat(bank, (col / blen) * blen + (lo + 2*p + 1) % blen);
    end
    id_bank[nid] = bank;
    id_ap[nid] = ap;
    nid++;
  endtask

  task automatic step(input bit rd, input int bank = 0, input int col = 0, input bit ap = 0);
    @(negedge clk_i);
    compare();
    rd_i = rd;
    rd_bank_i = BANK_W'(bank);
    rd_col_i = COL_W'(col);
    rd_ap_i = ap;
    if (rd) model_read(bank, col, ap);
    @(posedge clk_i);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 oe", DW'(dq_oe_o), '0);
    chk("R1 dqs_en", DW'(dqs_en_o), '0);
    chk("R1 dqs", DW'(dqs_o), '0);
    chk("R1 pre", DW'(pre_req_o), '0);
    chk("R1 rise", dq_rise_o, '0);
    rst_ni = 1'b1;
    idle(3);
    // R2 R3: BL4 CL2, odd start column
    cfg_bl_i = 2'd1; cfg_cl_i = 1'b0; dtag = "R3";
    step(1, 1, 5, 0); idle(6);
    // R4: BL8 CL3 wrap near block end, auto-precharge
    cfg_bl_i = 2'd2; cfg_cl_i = 1'b1; dtag = "R4";
    step(1, 2, 'h3D, 1); idle(8);
    // R4: BL2, reserved code 3 acts as BL8
    cfg_bl_i = 2'd0; cfg_cl_i = 1'b0;
    step(1, 3, 'h2FF, 1); idle(5);
    cfg_bl_i = 2'd3;
    step(1, 0, 'h106, 0); idle(8);
    // R8 R10: truncation of an auto-precharge BL8 burst after 2 clocks
    cfg_bl_i = 2'd2; cfg_cl_i = 1'b0; dtag = "R8"; ptag = "R10";
    step(1, 1, 'h10, 1); step(0); step(1, 2, 'h23, 1); idle(8);
    // R8: exact join, then cut to one pair, CL3 BL4
    cfg_bl_i = 2'd1; cfg_cl_i = 1'b1;
    step(1, 3, 'h7, 1); step(0); step(1, 0, 'h1, 0); step(1, 1, 'h3FE, 1); idle(8);
    // R8: READ every clock, BL8 CL2
    cfg_bl_i = 2'd2; cfg_cl_i = 1'b0;
    for (int i = 0; i < 5; i++) step(1, i % 4, 8 * i + 3, i[0]);
    idle(10);
    // R9: plain completed ap bursts on each bank
    dtag = "R3"; ptag = "R9";
    for (int b = 0; b < 4; b++) begin step(1, b, 'h40 + b, 1); idle(5); end
    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule